// File: doc/BRIEF.md
# Transmit Dominant-Timeout Guard

This block sits between the transmit pin of a serial controller and the enable of a single-wire bus driver. It watches the transmit line, where low requests the dominant bus level and high leaves the bus recessive. It passes a low through to the driver only while a dominant timer is running. The timer starts on a qualified falling edge of the synchronized line. If the low outlasts a tick-count limit, the guard drops the driver and latches it off, so the bus can float back to recessive even while the line stays stuck low. Only a rising edge on the transmit line releases the latch and re-arms the guard.

Two qualifiers gate the output. A mode-normal input must be high for any drive at all; while it is low, the timer is held idle. A fault-off input, raised for thermal or supply trouble, forces the driver off at once for as long as it is asserted. It does not disturb the timer. The default limit is 2,400,000 ticks, which is about 12 ms at a 200 MHz clock. The useful range runs from 5.5 ms to 20 ms of clock ticks.

Top module: `txd_timeout_guard`

## Requirements
- R1: While reset is asserted and after it is released, `drv_dominant` and `timeout_flag` are 0 until a qualified falling edge arms the timer.
- R2: If `txd_in` is sampled high at a clock edge and low at the next edge k, and stays low, `drv_dominant` becomes 1 right after edge k+2.
- R3: `drv_dominant` is never 1 for more than `TIMEOUT_TICKS` consecutive cycles. An uninterrupted low that outlasts the limit, in normal mode and without fault, gives exactly `TIMEOUT_TICKS` cycles of drive.
- R4: When the limit expires, `drv_dominant` goes to 0 and `timeout_flag` goes to 1. Both hold while `txd_in` stays low and `mode_normal` stays high.
- R5: If `txd_in` is first sampled high at edge k, both `drv_dominant` and `timeout_flag` are 0 right after edge k+2. A later falling edge arms the timer again.
- R6: While `fault_off` is 1, `drv_dominant` is 0 in that same cycle. The timer keeps running, so drive resumes when the fault clears if the timer has not expired.
- R7: While `mode_normal` is 0, both outputs are 0 and the timer returns to idle. Re-entering normal mode with `txd_in` already low does not drive.
- R8: A `txd_in` that is low when reset is released causes no drive until the line has been seen high and then low again.
- R9: `drv_dominant` and `timeout_flag` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txd_in | input | 1 | Asynchronous transmit line; 0 requests dominant |
| mode_normal | input | 1 | 1 allows transmission; 0 holds the guard idle |
| fault_off | input | 1 | 1 forces the driver off (thermal or undervoltage) |
| drv_dominant | output | 1 | 1 pulls the bus dominant |
| timeout_flag | output | 1 | 1 while the driver is latched off by expiry |

## Verification
On every cycle, the assertions enforce the following: the fault and mode gating of the outputs, the mutual exclusion of drive and flag, the bound on continuous drive, that arming only follows a falling edge, and that the latched state persists until a rising edge. Some behaviour depends on what the line did several cycles earlier, and only the bench scenarios can show it. This covers the exact two-edge latency from pin to drive, that the drive length equals the limit, re-arming after expiry, resuming after a fault, and refusing to drive on a line that was already low at reset release or at mode re-entry.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [1:0] {
        TG_IDLE    = 2'd0,
        TG_ARMED   = 2'd1,
        TG_TRIPPED = 2'd2
    } tg_state_e;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } line_evt_t;

    function automatic int unsigned tick_width(input longint unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/txg_line_sync.sv
module txg_line_sync
    import txg_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      txd_raw,
    output line_evt_t evt
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic [STAGES:0]   fill;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= txd_raw;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
            fill <= '0;
        end else begin
            prev <= chain[STAGES-1];
            fill <= {fill[STAGES-1:0], 1'b1};
        end
    end

    always_comb begin
        evt.level = chain[STAGES-1];
        evt.fall  = fill[STAGES] &  prev & ~chain[STAGES-1];
        evt.rise  = fill[STAGES] & ~prev &  chain[STAGES-1];
    end

endmodule

// File: rtl/txg_dom_timer.sv
module txg_dom_timer
    import txg_pkg::*;
#(
    parameter longint unsigned LIMIT = 2400000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  line_evt_t evt,
    output tg_state_e state
);
    localparam int unsigned CW = tick_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= TG_IDLE;
            cnt   <= '0;
        end else if (evt.rise) begin
            state <= TG_IDLE;
            cnt   <= '0;
        end else if (evt.fall) begin
            state <= TG_ARMED;
            cnt   <= '0;
        end else if (state == TG_ARMED) begin
            if (cnt == LAST) state <= TG_TRIPPED;
            else             cnt   <= cnt + 1'b1;
        end
    end

    // R2: the timer only enters the armed state after a qualified falling edge
    p_arm_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (state == TG_ARMED && $past(state) != TG_ARMED) |-> $past(evt.fall));

    // R4: the latched state persists until a rising edge or leaving normal mode
    p_trip_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (state == TG_TRIPPED && enable && !evt.rise) |=> state == TG_TRIPPED);

    // R3: the counter never passes the limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/txg_drive_gate.sv
module txg_drive_gate
    import txg_pkg::*;
(
    input  tg_state_e state,
    input  logic      mode_normal,
    input  logic      fault_off,
    output logic      drv_dominant,
    output logic      timeout_flag
);
    always_comb begin
        drv_dominant = (state == TG_ARMED) & mode_normal & ~fault_off;
        timeout_flag = (state == TG_TRIPPED) & mode_normal;
    end
endmodule

// File: rtl/txd_timeout_guard.sv
module txd_timeout_guard
    import txg_pkg::*;
#(
    parameter longint unsigned TIMEOUT_TICKS = 2400000,
    parameter int unsigned     SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic txd_in,
    input  logic mode_normal,
    input  logic fault_off,
    output logic drv_dominant,
    output logic timeout_flag
);
    localparam int unsigned RW = tick_width(TIMEOUT_TICKS + 1);

    line_evt_t evt;
    tg_state_e state;

    txg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .txd_raw (txd_in),
        .evt     (evt)
    );

    txg_dom_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .enable (mode_normal),
        .evt    (evt),
        .state  (state)
    );

    txg_drive_gate u_gate (
        .state        (state),
        .mode_normal  (mode_normal),
        .fault_off    (fault_off),
        .drv_dominant (drv_dominant),
        .timeout_flag (timeout_flag)
    );

    // checker: length of the current continuous drive
    logic [RW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)               run_len <= '0;
        else if (drv_dominant) run_len <= run_len + 1'b1;
        else                   run_len <= '0;
    end

    p_run_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run_len <= RW'(TIMEOUT_TICKS));

    p_fault_off_r6: assert property (@(posedge clk) disable iff (rst)
        fault_off |-> !drv_dominant);

    p_mode_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !mode_normal |-> (!drv_dominant && !timeout_flag));

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(drv_dominant && timeout_flag));

endmodule

// File: tb/sim_txd_timeout_guard.sv
`timescale 1ns/1ps
module sim_txd_timeout_guard;
    localparam int L = 20;

    logic clk = 1'b0;
    logic rst, txd, mode, fault;
    logic drv, flag;

    always #2.5 clk = ~clk;

    txd_timeout_guard #(.TIMEOUT_TICKS(L), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .txd_in(txd), .mode_normal(mode),
        .fault_off(fault), .drv_dominant(drv), .timeout_flag(flag)
    );

    int tests = 0, fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 counting, 2 latched off
    int m_st = 0, m_cnt = 0;
    bit hist[$];
    int n;
    bit fl, rs;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; hist.delete();
        end else begin
            n = hist.size(); fl = 0; rs = 0;
            if (n >= 3) begin
                fl = hist[n-3] && !hist[n-2];
                rs = !hist[n-3] && hist[n-2];
            end
            if (!mode)      begin m_st = 0; m_cnt = 0; end
            else if (rs)    begin m_st = 0; m_cnt = 0; end
            else if (fl)    begin m_st = 1; m_cnt = 0; end
            else if (m_st == 1) begin
                if (m_cnt == L - 1) m_st = 2;
                else m_cnt++;
            end
            hist.push_back(txd);
            if (hist.size() > 8) void'(hist.pop_front());
        end
    end

    int run = 0, maxrun = 0;

    task automatic chk(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk(cur_req, drv, (m_st == 1) && mode && !fault);
            chk(cur_req, flag, (m_st == 2) && mode);
            if (drv === 1'b1) run++; else run = 0;
            if (run > maxrun) maxrun = run;
        end
    end

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; txd = 1; mode = 1; fault = 0;
        step(5);
        chk("R1", drv, 1'b0); chk("R1", flag, 1'b0);
        rst = 0;
        step(5);
        chk("R1", drv, 1'b0); chk("R1", flag, 1'b0);

        // R2 fall latency, short pulse, R5 release latency
        cur_req = "R2";
        txd = 0;
        step(1); chk("R2", drv, 1'b0);
        step(1); chk("R2", drv, 1'b0);
        step(1); chk("R2", drv, 1'b1);
        step(5);
        cur_req = "R5";
        txd = 1;
        step(1); chk("R5", drv, 1'b1);
        step(1); chk("R5", drv, 1'b1);
        step(1); chk("R5", drv, 1'b0); chk("R5", flag, 1'b0);
        step(5);

        // R3 / R4 expiry and exact drive length
        cur_req = "R4";
        maxrun = 0;
        txd = 0;
        step(40);
        chk("R4", flag, 1'b1); chk("R4", drv, 1'b0);
        tests++;
        if (maxrun != L) begin
            fails++;
            $display("FAIL R3 actual=%0d expected=%0d", maxrun, L);
        end
        cur_req = "R5";
        txd = 1;
        step(3); chk("R5", flag, 1'b0);
        step(3);
        txd = 0;
        step(3); chk("R5", drv, 1'b1);

        // R6 fault forcing and resume
        cur_req = "R6";
        step(3);
        fault = 1;
        step(1); chk("R6", drv, 1'b0);
        step(3);
        fault = 0;
        step(1); chk("R6", drv, 1'b1);
        step(30); chk("R4", flag, 1'b1);
        txd = 1;
        step(5);

        // R7 mode gating and re-entry with low line
        cur_req = "R7";
        txd = 0;
        step(5);
        mode = 0;
        step(1); chk("R7", drv, 1'b0); chk("R7", flag, 1'b0);
        step(5);
        mode = 1;
        step(5); chk("R7", drv, 1'b0);
        txd = 1; step(5);
        txd = 0; step(4); chk("R7", drv, 1'b1);
        txd = 1; step(5);

        // R8 line low at reset release
        cur_req = "R8";
        txd = 0; rst = 1;
        step(4);
        rst = 0;
        step(10); chk("R8", drv, 1'b0); chk("R8", flag, 1'b0);
        txd = 1; step(5);
        txd = 0; step(3); chk("R8", drv, 1'b1);
        txd = 1; step(5);

        // R9 exclusion is checked on every cycle by the reference compare
        cur_req = "R9";
        step(2);

        summary();
        $finish;
    end
endmodule